// File: doc/BRIEF.md
# I2C Master Bus-Timing Generator

This block produces the clock (SCL) and data (SDA) line drives of an I2C bus master from a single system clock. A divider input and a speed-mode select set a half period H, counted in system-clock cycles. Every bus event is timed as a fixed cycle count derived from H: the start condition, the repeated start, each data bit, the acknowledge clock and the stop condition. The bus-free gap that follows a stop is timed the same way.

A controlling state machine drives simple one-cycle command strobes: start, write byte, read byte and stop. After a start condition or a completed byte, the generator parks with SCL held low and raises `ready`. It then waits there for the next strobe. Bytes go out MSB first, and a ninth clock carries the acknowledge. The generator samples the bus in the middle of every SCL high phase. This captures read data and the slave's acknowledge.

Both line outputs model open-drain drive enables. A value of 0 pulls the line low, and a value of 1 releases it. The bus value read back at `sda_in` is the wired-AND of all drivers.

Top module: `i2cm_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, both lines are released (1), and `busy`, `ready` and `byte_done` are 0.
- R2: H equals `div_cfg` when `fast_mode`=1 and 4*`div_cfg` when `fast_mode`=0, and any result below 4 is raised to 4. H is captured when a start is accepted from idle and is unaffected by `div_cfg`/`fast_mode` until the next such start. Within a byte, SCL stays high exactly H cycles, and SCL low lasts exactly H cycles from its falling edge to its next rising edge.
- R3: A start from idle pulls SDA low and raises `busy` on the accepting edge, with SCL high. SCL falls H-1 cycles later.
- R4: Inside a byte, SDA changes exactly 3 cycles after SCL falls and H-3 cycles before SCL rises. The first bit of a byte changes SDA on the edge that accepts the command, which is at least 3 cycles after SCL fell.
- R5: Write byte sends `tx_data` MSB first on 8 clocks, then releases SDA for a ninth clock. `ack_rx` holds the bus value sampled during that ninth SCL high phase (0 = acknowledged). `byte_done` is a one-cycle pulse on the edge where the ninth SCL falls.
- R6: Read byte releases SDA for 8 clocks and shifts the sampled bus into `rx_data` MSB first. On the ninth clock the master drives the value of `rd_nack` captured at command time (0 = acknowledge, 1 = release). `byte_done` pulses as in R5.
- R7: Stop pulls SDA low on the accepting edge. SCL rises H-3 cycles later, and SDA rises H+2 cycles after SCL rises.
- R8: After the SDA rise of a stop, `busy` stays 1 for H-1 more cycles and then falls. A start strobe while `busy`=1 and `ready`=0 has no effect.
- R9: Repeated start (start strobe while `ready`) releases SDA on the accepting edge. SCL rises H-3 cycles later, and SDA falls 2H cycles after SCL rises. SCL then falls H-1 cycles after SDA.
- R10: `ready` rises exactly 3 cycles after the SCL fall that ends a start condition or a byte, and is 1 only while SCL is held low waiting. In that state the strobes take priority start, then stop, then write, then read. Write, read and stop strobes in idle have no effect.
- R11: SCL and SDA never change on the same clock edge. SDA changes while SCL is high only for start, repeated start and stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | DIV_W | Divider setting that sets the half period |
| fast_mode | input | 1 | 1 = fast mode (H = div), 0 = standard (H = 4*div) |
| cmd_start | input | 1 | Start or repeated-start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_write | input | 1 | Write-byte strobe |
| cmd_read | input | 1 | Read-byte strobe |
| tx_data | input | BYTE_W | Byte to send, captured with cmd_write |
| rd_nack | input | 1 | Acknowledge value for a read, captured with cmd_read |
| sda_in | input | 1 | Sampled bus level of SDA |
| scl_o | output | 1 | SCL drive enable, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive enable, 0 pulls low, 1 releases |
| busy | output | 1 | High from start until the bus-free time ends |
| ready | output | 1 | Holding SCL low, waiting for a command |
| byte_done | output | 1 | One-cycle pulse at the end of a byte |
| rx_data | output | BYTE_W | Last byte read |
| ack_rx | output | 1 | Acknowledge level sampled on the ninth clock |

## Verification
A wrong phase counter or wrong load value shows up as an SCL or SDA edge that arrives one or more cycles early or late. The edge is visible at the ports on the very edge where it should have happened, so each expected edge is checked one cycle before it and on the cycle it occurs. A byte path that has lost its bit index shows a wrong SDA level within the next bit and a misplaced `byte_done` pulse at the end of the byte. A stale captured half period makes every interval of the next transaction wrong from the first start-hold onwards.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C master timing generator.
package i2cm_pkg;

    // Bus phase of the sequencer; each phase lasts a counted number of cycles.
    typedef enum logic [3:0] {
        ST_IDLE,      // bus free, both lines released
        ST_S_HOLD,    // SDA low, SCL high: start hold
        ST_L_HOLD,    // SCL low, SDA held after the falling edge
        ST_WAIT,      // SCL low, waiting for a command
        ST_L_SETUP,   // SCL low, SDA at its new value
        ST_HIGH,      // SCL high during a data or acknowledge bit
        ST_P_SETUP,   // SCL high, SDA low: stop setup
        ST_BUS_FREE,  // both released, bus-free time running
        ST_RS_SETUP   // SCL high, SDA released: repeated-start setup
    } phase_t;

    // What the rising SCL edge after a low-setup phase leads into.
    typedef enum logic [1:0] {
        SK_DATA,
        SK_STOP,
        SK_RSTART
    } setup_kind_t;

endpackage

// File: rtl/i2cm_intervals.sv
// Half-period capture and interval load values.
// Captures the half period H from the divider and speed mode when a start
// is accepted from idle, and derives the counter load value for every bus
// phase. Assumes HOLD_CYC >= 1; H is never below HOLD_CYC + 1.
module i2cm_intervals #(
    parameter int DIV_W    = 8,
    parameter int HOLD_CYC = 3,
    parameter int CNT_W    = DIV_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             fast_mode,
    output logic [CNT_W-1:0] ld_start,
    output logic [CNT_W-1:0] ld_setup,
    output logic [CNT_W-1:0] ld_high,
    output logic [CNT_W-1:0] ld_stop,
    output logic [CNT_W-1:0] ld_rs,
    output logic [CNT_W-1:0] ld_free,
    output logic [CNT_W-1:0] ld_hold,
    output logic [CNT_W-1:0] sample_pt
);
    localparam int MIN_HALF = HOLD_CYC + 1;

    logic [CNT_W-1:0] h_q;
    logic [CNT_W-1:0] h_raw;
    logic [CNT_W-1:0] h_new;
    logic [CNT_W-1:0] h_use;

    // Scale the divider by speed mode and clamp to the minimum half period.
    always_comb begin
        h_raw = fast_mode ? CNT_W'(div_cfg) : (CNT_W'(div_cfg) << 2);
        h_new = (h_raw < CNT_W'(MIN_HALF)) ? CNT_W'(MIN_HALF) : h_raw;
        h_use = load ? h_new : h_q;
    end

    // Hold the captured half period for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= CNT_W'(MIN_HALF);
        end else if (load) begin
            h_q <= h_new;
        end
    end

    // Counter load values: a phase of N cycles loads N-1.
    always_comb begin
        ld_start  = h_use - CNT_W'(2);
        ld_free   = h_use - CNT_W'(2);
        ld_setup  = h_use - CNT_W'(HOLD_CYC + 1);
        ld_high   = h_use - CNT_W'(1);
        ld_stop   = h_use + CNT_W'(1);
        ld_rs     = (h_use << 1) - CNT_W'(1);
        ld_hold   = CNT_W'(HOLD_CYC - 1);
        sample_pt = h_use >> 1;
    end

    AST_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        h_q >= CNT_W'(MIN_HALF)); // R2
    AST_HALF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(h_q)); // R2

endmodule

// File: rtl/i2cm_bytepath.sv
// Byte shift path.
// Holds the byte being sent or received, the bit index within the nine
// clocks of a byte, and the captured acknowledge. bit_end marks the SCL
// fall that ends a bit; sample_en marks the middle of SCL high.
// Assumes bit_end and sample_en only occur while a byte is active.
module i2cm_bytepath #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic              load_rd,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rd_nack,
    input  logic              bit_end,
    input  logic              sample_en,
    input  logic              sda_in,
    output logic              active,
    output logic              on_ack,
    output logic              drive_bit,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_rx
);
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              rd_q;
    logic              nack_q;
    logic              ack_q;

    // Current bit is the acknowledge clock.
    always_comb on_ack = (idx_q == IDX_W'(BYTE_W));

    // Master drive level for the current bit.
    always_comb begin
        if (rd_q) drive_bit = on_ack ? nack_q : 1'b1;
        else      drive_bit = on_ack ? 1'b1 : tx_sh[BYTE_W-1];
    end

    // Bit index, transmit shift and direction capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            active <= 1'b0;
            rd_q   <= 1'b0;
            nack_q <= 1'b1;
            tx_sh  <= '0;
        end else if (load_wr || load_rd) begin
            idx_q  <= '0;
            active <= 1'b1;
            rd_q   <= load_rd;
            nack_q <= rd_nack;
            tx_sh  <= tx_data;
        end else if (bit_end) begin
            tx_sh <= tx_sh << 1;
            if (on_ack) begin
                idx_q  <= '0;
                active <= 1'b0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Capture read data and the acknowledge level mid SCL high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
            ack_q <= 1'b1;
        end else if (sample_en && active) begin
            if (on_ack)    ack_q <= sda_in;
            else if (rd_q) rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
        end
    end

    always_comb begin
        rx_data = rx_sh;
        ack_rx  = ack_q;
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(BYTE_W)); // R5
    AST_NO_BIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> active); // R5

endmodule

// File: rtl/i2cm_timing_gen.sv
// I2C master bus-timing generator (top).
// Sequences start, repeated start, data bits, acknowledge and stop with a
// single down-counter whose load values come from i2cm_intervals. Line
// outputs are registered drive enables (0 = pull low, 1 = release).
// Assumes command strobes are one cycle wide; strobes outside idle (start)
// or the wait phase (all) are ignored. No clock stretching is observed.
module i2cm_timing_gen #(
    parameter int DIV_W    = 8,
    parameter int BYTE_W   = 8,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              fast_mode,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_write,
    input  logic              cmd_read,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rd_nack,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              busy,
    output logic              ready,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_data,
    output logic              ack_rx
);
    import i2cm_pkg::*;

    localparam int CNT_W = DIV_W + 3;

    phase_t           state;
    setup_kind_t      kind;
    logic [CNT_W-1:0] cnt;
    logic             scl_q;
    logic             sda_q;
    logic             done_q;
    logic             cnt_zero;

    logic [CNT_W-1:0] ld_start, ld_setup, ld_high, ld_stop;
    logic [CNT_W-1:0] ld_rs, ld_free, ld_hold, sample_pt;

    logic iv_load;
    logic bp_wr, bp_rd, bp_bit_end, bp_sample;
    logic bp_active, bp_on_ack, bp_drive;

    // Strobes toward the interval and byte-path blocks.
    always_comb begin
        cnt_zero   = (cnt == '0);
        iv_load    = (state == ST_IDLE) && cmd_start;
        bp_wr      = (state == ST_WAIT) && !cmd_start && !cmd_stop && cmd_write;
        bp_rd      = (state == ST_WAIT) && !cmd_start && !cmd_stop && !cmd_write && cmd_read;
        bp_bit_end = (state == ST_HIGH) && cnt_zero;
        bp_sample  = (state == ST_HIGH) && (cnt == sample_pt);
    end

    i2cm_intervals #(
        .DIV_W    (DIV_W),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_intervals (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (iv_load),
        .div_cfg   (div_cfg),
        .fast_mode (fast_mode),
        .ld_start  (ld_start),
        .ld_setup  (ld_setup),
        .ld_high   (ld_high),
        .ld_stop   (ld_stop),
        .ld_rs     (ld_rs),
        .ld_free   (ld_free),
        .ld_hold   (ld_hold),
        .sample_pt (sample_pt)
    );

    i2cm_bytepath #(
        .BYTE_W (BYTE_W)
    ) u_bytepath (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_wr   (bp_wr),
        .load_rd   (bp_rd),
        .tx_data   (tx_data),
        .rd_nack   (rd_nack),
        .bit_end   (bp_bit_end),
        .sample_en (bp_sample),
        .sda_in    (sda_in),
        .active    (bp_active),
        .on_ack    (bp_on_ack),
        .drive_bit (bp_drive),
        .rx_data   (rx_data),
        .ack_rx    (ack_rx)
    );

    // Phase sequencer: counts each phase down and moves one line per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= SK_DATA;
            cnt    <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        sda_q <= 1'b0;
                        cnt   <= ld_start;
                        state <= ST_S_HOLD;
                    end
                end
                ST_S_HOLD: begin
                    if (cnt_zero) begin
                        scl_q <= 1'b0;
                        cnt   <= ld_hold;
                        state <= ST_L_HOLD;
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_L_HOLD: begin
                    if (cnt_zero) begin
                        if (bp_active) begin
                            sda_q <= bp_drive;
                            kind  <= SK_DATA;
                            cnt   <= ld_setup;
                            state <= ST_L_SETUP;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_WAIT: begin
                    if (cmd_start || cmd_stop || cmd_write || cmd_read) begin
                        cnt   <= ld_setup;
                        state <= ST_L_SETUP;
                        if (cmd_start) begin
                            sda_q <= 1'b1;
                            kind  <= SK_RSTART;
                        end else if (cmd_stop) begin
                            sda_q <= 1'b0;
                            kind  <= SK_STOP;
                        end else begin
                            sda_q <= cmd_write ? tx_data[BYTE_W-1] : 1'b1;
                            kind  <= SK_DATA;
                        end
                    end
                end
                ST_L_SETUP: begin
                    if (cnt_zero) begin
                        scl_q <= 1'b1;
                        case (kind)
                            SK_STOP: begin
                                cnt   <= ld_stop;
                                state <= ST_P_SETUP;
                            end
                            SK_RSTART: begin
                                cnt   <= ld_rs;
                                state <= ST_RS_SETUP;
                            end
                            default: begin
                                cnt   <= ld_high;
                                state <= ST_HIGH;
                            end
                        endcase
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_HIGH: begin
                    if (cnt_zero) begin
                        scl_q  <= 1'b0;
                        cnt    <= ld_hold;
                        state  <= ST_L_HOLD;
                        done_q <= bp_on_ack;
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_P_SETUP: begin
                    if (cnt_zero) begin
                        sda_q <= 1'b1;
                        cnt   <= ld_free;
                        state <= ST_BUS_FREE;
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_BUS_FREE: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt   <= cnt - CNT_W'(1);
                end
                ST_RS_SETUP: begin
                    if (cnt_zero) begin
                        sda_q <= 1'b0;
                        cnt   <= ld_start;
                        state <= ST_S_HOLD;
                    end else cnt <= cnt - CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port view of the sequencer state.
    always_comb begin
        scl_o     = scl_q;
        sda_o     = sda_q;
        busy      = (state != ST_IDLE);
        ready     = (state == ST_WAIT);
        byte_done = done_q;
    end

    AST_ONE_LINE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_q) |-> $stable(sda_q)); // R11
    AST_SDA_MOVES_HIGH_ONLY_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && !$stable(sda_q)) |-> (state == ST_S_HOLD || state == ST_BUS_FREE)); // R11
    AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($fell(sda_q) && scl_q)); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (scl_q && sda_q)); // R8
    AST_READY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !scl_q); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5

endmodule

// File: tb/test_i2cm_timing_gen.sv
// Bench: sweeps speed mode and divider settings, runs a full transaction
// per setting and checks every line edge one cycle before and on its cycle.
module test_i2cm_timing_gen;
    localparam int DIV_W  = 8;
    localparam int BYTE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [DIV_W-1:0]  div_cfg;
    logic              fast_mode;
    logic              cmd_start, cmd_stop, cmd_write, cmd_read;
    logic [BYTE_W-1:0] tx_data;
    logic              rd_nack;
    logic              slave_sda;
    logic              sda_in;
    logic              scl_o, sda_o, busy, ready, byte_done, ack_rx;
    logic [BYTE_W-1:0] rx_data;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    int h = 4;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign sda_in = sda_o & slave_sda;

    i2cm_timing_gen #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) i_i2cm_timing_gen (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .fast_mode(fast_mode),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write),
        .cmd_read(cmd_read), .tx_data(tx_data), .rd_nack(rd_nack),
        .sda_in(sda_in), .scl_o(scl_o), .sda_o(sda_o), .busy(busy),
        .ready(ready), .byte_done(byte_done), .rx_data(rx_data), .ack_rx(ack_rx)
    );

    task automatic check_val(string tag, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d, H=%0d)", tag, got, exp, cyc, h);
        end
    endtask

    task automatic wait_cyc(int k);
        if (cyc > k) check_val("bench schedule", cyc, k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic chk_lines(int k, int scl_e, int sda_e, string tag);
        wait_cyc(k);
        check_val({tag, " SCL"}, int'(scl_o), scl_e);
        check_val({tag, " SDA"}, int'(sda_o), sda_e);
    endtask

    // which: 0 start, 1 stop, 2 write, 3 read; c returns the accepting edge.
    task automatic issue(int which, output int c);
        cmd_start = (which == 0);
        cmd_stop  = (which == 1);
        cmd_write = (which == 2);
        cmd_read  = (which == 3);
        @(posedge clk);
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_write = 1'b0; cmd_read = 1'b0;
        c = cyc;
    endtask

    task automatic wait_ready(int fe);
        wait_cyc(fe + 2);
        check_val("R10 ready too early", int'(ready), 0);
        wait_cyc(fe + 3);
        check_val("R10 ready after hold", int'(ready), 1);
    endtask

    task automatic do_start();
        int c;
        check_val("R3 busy before start", int'(busy), 0);
        issue(0, c);
        check_val("R3 busy on start", int'(busy), 1);
        chk_lines(c, 1, 0, "R3 start SDA fall");
        chk_lines(c + h - 2, 1, 0, "R3 start hold");
        chk_lines(c + h - 1, 0, 0, "R3 start SCL fall");
        wait_ready(c + h - 1);
    endtask

    task automatic do_byte(bit is_rd, logic [7:0] tx, logic [7:0] rxs, bit ackb);
        int t, r, f, m, mp;
        slave_sda = is_rd ? rxs[7] : ackb;
        rd_nack   = ackb;
        tx_data   = tx;
        issue(is_rd ? 3 : 2, t);
        f = 0; mp = 0;
        for (int i = 0; i < 9; i++) begin
            if (i == 8) m = is_rd ? int'(ackb) : 1;
            else        m = is_rd ? 1 : int'(tx[7-i]);
            if (i > 0) begin
                t = f + 3;
                chk_lines(t - 1, 0, mp, "R4 data hold");
            end
            chk_lines(t, 0, m, is_rd ? "R6 master drive" : "R5 master drive");
            r = t + h - 3;
            chk_lines(r - 1, 0, m, "R4 data setup");
            chk_lines(r, 1, m, "R2 SCL rise");
            f = r + h;
            chk_lines(f - 1, 1, m, "R2 SCL high");
            chk_lines(f, 0, m, "R2 SCL fall");
            if (i < 8) slave_sda = is_rd ? ((i < 7) ? rxs[6-i] : 1'b1) : ackb;
            mp = m;
        end
        check_val(is_rd ? "R6 byte_done" : "R5 byte_done", int'(byte_done), 1);
        if (is_rd) check_val("R6 rx_data", int'(rx_data), int'(rxs));
        else       check_val("R5 ack_rx", int'(ack_rx), int'(ackb));
        slave_sda = 1'b1;
        wait_cyc(f + 1);
        check_val("R5 byte_done one cycle", int'(byte_done), 0);
        wait_ready(f);
    endtask

    task automatic do_rstart();
        int c, r, s, e;
        issue(0, c);
        chk_lines(c, 0, 1, "R9 SDA release");
        check_val("R9 busy held", int'(busy), 1);
        r = c + h - 3;
        chk_lines(r - 1, 0, 1, "R9 low setup");
        chk_lines(r, 1, 1, "R9 SCL rise");
        s = r + 2 * h;
        chk_lines(s - 1, 1, 1, "R9 repeated-start setup");
        chk_lines(s, 1, 0, "R9 SDA fall");
        e = s + h - 1;
        chk_lines(e - 1, 1, 0, "R9 start hold");
        chk_lines(e, 0, 0, "R9 SCL fall");
        wait_ready(e);
    endtask

    task automatic do_stop();
        int c, r, s;
        issue(1, c);
        chk_lines(c, 0, 0, "R7 SDA low");
        r = c + h - 3;
        chk_lines(r - 1, 0, 0, "R7 low setup");
        chk_lines(r, 1, 0, "R7 SCL rise");
        s = r + h + 2;
        chk_lines(s - 1, 1, 0, "R7 stop setup");
        chk_lines(s, 1, 1, "R7 SDA rise");
        check_val("R8 busy after stop edge", int'(busy), 1);
        cmd_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_start = 1'b0;
        chk_lines(s + 1, 1, 1, "R8 start ignored in bus-free");
        wait_cyc(s + h - 2);
        check_val("R8 busy during bus-free", int'(busy), 1);
        wait_cyc(s + h - 1);
        check_val("R8 busy cleared", int'(busy), 0);
        chk_lines(s + h - 1, 1, 1, "R8 idle lines");
    endtask

    // R11 monitor: never both lines on one edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if ((scl_o !== prev_scl) || (sda_o !== prev_sda)) begin
                n_vec++;
                if ((scl_o !== prev_scl) && (sda_o !== prev_sda)) begin
                    n_bad++;
                    $display("FAIL R11: both lines changed at cycle %0d (scl %0d sda %0d)", cyc, scl_o, sda_o);
                end
            end
        end
        prev_scl <= scl_o;
        prev_sda <= sda_o;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int c, raw;
        rst_n = 1'b0; div_cfg = '0; fast_mode = 1'b1;
        cmd_start = 1'b0; cmd_stop = 1'b0; cmd_write = 1'b0; cmd_read = 1'b0;
        tx_data = '0; rd_nack = 1'b1; slave_sda = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check_val("R1 SCL in reset", int'(scl_o), 1);
        check_val("R1 SDA in reset", int'(sda_o), 1);
        check_val("R1 busy in reset", int'(busy), 0);
        check_val("R1 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 SCL after reset", int'(scl_o), 1);
        check_val("R1 byte_done after reset", int'(byte_done), 0);

        for (int cfg = 0; cfg < 7; cfg++) begin
            case (cfg)
                0: begin fast_mode = 1'b0; div_cfg = 8'd1; end
                1: begin fast_mode = 1'b0; div_cfg = 8'd2; end
                2: begin fast_mode = 1'b0; div_cfg = 8'd0; end
                3: begin fast_mode = 1'b1; div_cfg = 8'd5; end
                4: begin fast_mode = 1'b1; div_cfg = 8'd7; end
                5: begin fast_mode = 1'b1; div_cfg = 8'd2; end
                default: begin fast_mode = 1'b1; div_cfg = 8'd6; end
            endcase
            raw = fast_mode ? int'(div_cfg) : 4 * int'(div_cfg);
            h = (raw < 4) ? 4 : raw;
            @(negedge clk);
            chk_lines(cyc, 1, 1, "R8 idle before start");
            if (cfg == 0) begin
                issue(2, c);
                chk_lines(c, 1, 1, "R10 write ignored in idle");
                check_val("R10 busy after idle write", int'(busy), 0);
                issue(1, c);
                chk_lines(c, 1, 1, "R10 stop ignored in idle");
            end
            do_start();
            // R2: divider changes after capture must not alter timing
            div_cfg = 8'd50;
            fast_mode = ~fast_mode;
            do_byte(1'b0, 8'hA5, 8'h00, 1'b0);
            @(negedge clk);
            do_byte(1'b1, 8'h00, 8'h3C, 1'b1);
            do_byte(1'b0, 8'h5A, 8'h00, 1'b1);
            do_rstart();
            do_byte(1'b0, 8'hC3, 8'h00, 1'b0);
            repeat (2) @(negedge clk);
            do_byte(1'b1, 8'h00, 8'h96, 1'b0);
            do_stop();
            repeat (2) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule